// File: doc/BRIEF.md
# Decode-Stage Branch Hazard and Redirect Control

This block resolves conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. It holds an equality comparator for the two register operands of the branch and an adder that forms the branch target. It looks at up to three older instructions still in flight, one each in execute, memory and writeback. For each of these it sees the destination register, whether the instruction writes a register, and, for the memory stage, whether the instruction is a load.

For each comparator operand the block picks one of three sources: the register file, the memory-stage ALU result, or the writeback value. When the needed value does not exist yet, the block raises a stall instead. While stall is high the surrounding pipeline holds the PC and the fetch/decode register and sends a bubble into execute. As the pipeline advances, the block looks at the branch again on every cycle. An adjacent ALU producer costs one stall cycle. A load two instructions ahead also costs one stall cycle. An adjacent load costs two stall cycles. A producer two or three instructions ahead costs nothing, because its value is forwarded.

When the branch is taken and not stalled, the block selects the target as the next PC. It also flushes the single instruction that was fetched after the branch.

Top module: `branch_hazard_ctl`

## Requirements
- R1: `br_target` equals `id_pc_plus4` plus the sign-extended 16-bit `id_offset` shifted left by two bits, modulo 2^XLEN.
- R2: `pc_sel` and `flush` are both 1 exactly when `id_branch` is 1, `stall` is 0, and the two selected comparator operands are equal. Otherwise both are 0.
- R3: A branch whose rs or rt is written by the execute-stage instruction raises `stall`, whatever that instruction's kind. For an adjacent ALU producer this gives one stall cycle, because on the next cycle the value is forwarded from the memory stage.
- R4: A branch whose rs or rt is written by a load in the memory stage raises `stall`.
- R5: Forward select encoding: 0 = register file, 1 = memory-stage ALU result, 2 = writeback value. A non-load memory-stage producer gives select 1 with no stall. A writeback-stage producer gives select 2 with no stall.
- R6: With an adjacent load producer, the branch stays in decode for three consecutive cycles: two stall cycles, then resolution using the writeback value.
- R7: A producer whose destination is register 0, or whose write enable is 0, creates no dependency. It causes no stall and no forward select.
- R8: When the memory and writeback stages both write the same operand register, that operand's select is 1, the youngest producer.
- R9: When `id_branch` is 0, `stall`, `flush` and `pc_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded checks |
| rst_n | input | 1 | Active-low reset; disables the checks |
| id_branch | input | 1 | Decode stage holds a conditional branch |
| id_rs | input | REGW | First compared register number |
| id_rt | input | REGW | Second compared register number |
| id_rs_val | input | XLEN | Register-file read of rs |
| id_rt_val | input | XLEN | Register-file read of rt |
| id_pc_plus4 | input | XLEN | Address of the branch plus four |
| id_offset | input | 16 | Branch offset field, in words |
| ex_dst | input | REGW | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REGW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_val | input | XLEN | Memory-stage ALU result |
| wb_dst | input | REGW | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_val | input | XLEN | Value being written back |
| fwd_a | output | 2 | Source select for the rs operand |
| fwd_b | output | 2 | Source select for the rt operand |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| flush | output | 1 | Squash the instruction fetched after the branch |
| pc_sel | output | 1 | 1 = next PC is the branch target |
| br_target | output | XLEN | Computed branch target |

## Verification
The assertions check four things on every cycle: a stalled branch never redirects, a non-branch never stalls or redirects, a dependency on the execute stage or on a memory-stage load always stalls, and the youngest producer wins the select. Some behaviour only the bench scenarios can show, because it depends on how the pipeline moves around the block. These are the one-cycle and two-cycle stall lengths as the producer moves from stage to stage, the value the comparator actually uses under each select, and the target arithmetic with negative offsets.

// File: rtl/branch_hazard_ctl.sv
module branch_hazard_ctl #(
  parameter int XLEN = 32,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_branch,
  input  logic [REGW-1:0] id_rs,
  input  logic [REGW-1:0] id_rt,
  input  logic [XLEN-1:0] id_rs_val,
  input  logic [XLEN-1:0] id_rt_val,
  input  logic [XLEN-1:0] id_pc_plus4,
  input  logic [15:0]     id_offset,
  input  logic [REGW-1:0] ex_dst,
  input  logic            ex_wen,
  input  logic [REGW-1:0] mem_dst,
  input  logic            mem_wen,
  input  logic            mem_load,
  input  logic [XLEN-1:0] mem_alu_val,
  input  logic [REGW-1:0] wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] wb_val,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            stall,
  output logic            flush,
  output logic            pc_sel,
  output logic [XLEN-1:0] br_target
);
  localparam logic [1:0] SRC_RF  = 2'd0;
  localparam logic [1:0] SRC_MEM = 2'd1;
  localparam logic [1:0] SRC_WB  = 2'd2;
  localparam int         SEXT    = XLEN - 18;

  function automatic logic writes(input logic wen, input logic [REGW-1:0] dst,
                                  input logic [REGW-1:0] src);
    return wen && (dst != '0) && (dst == src);
  endfunction

  logic ex_a, ex_b, mem_a, mem_b, wb_a, wb_b;
  assign ex_a  = writes(ex_wen,  ex_dst,  id_rs);
  assign ex_b  = writes(ex_wen,  ex_dst,  id_rt);
  assign mem_a = writes(mem_wen, mem_dst, id_rs);
  assign mem_b = writes(mem_wen, mem_dst, id_rt);
  assign wb_a  = writes(wb_wen,  wb_dst,  id_rs);
  assign wb_b  = writes(wb_wen,  wb_dst,  id_rt);

  assign fwd_a = mem_a ? SRC_MEM : (wb_a ? SRC_WB : SRC_RF);
  assign fwd_b = mem_b ? SRC_MEM : (wb_b ? SRC_WB : SRC_RF);

  assign stall = id_branch && (ex_a || ex_b || (mem_load && (mem_a || mem_b)));

  logic [XLEN-1:0] opa, opb;
  always_comb begin
    unique case (fwd_a)
      SRC_MEM: opa = mem_alu_val;
      SRC_WB:  opa = wb_val;
      default: opa = id_rs_val;
    endcase
    unique case (fwd_b)
      SRC_MEM: opb = mem_alu_val;
      SRC_WB:  opb = wb_val;
      default: opb = id_rt_val;
    endcase
  end

  logic taken;
  assign taken     = id_branch && !stall && (opa == opb);
  assign pc_sel    = taken;
  assign flush     = taken;
  assign br_target = id_pc_plus4 + {{SEXT{id_offset[15]}}, id_offset, 2'b00};

  a_r2_no_redirect_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !pc_sel && !flush);

  a_r9_quiet_without_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !id_branch |-> !stall && !pc_sel && !flush);

  a_r3_ex_producer_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && ex_wen && ex_dst != '0 && (ex_dst == id_rs || ex_dst == id_rt)) |-> stall);

  a_r4_mem_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && mem_load && (fwd_a == SRC_MEM || fwd_b == SRC_MEM)) |-> stall);

  a_r8_youngest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && mem_dst != '0 && mem_dst == id_rs) |-> fwd_a == SRC_MEM);

  a_r5_select_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a != 2'd3 && fwd_b != 2'd3);

  a_r7_zero_reg_free: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> fwd_a == SRC_RF);
endmodule

// File: tb/test_branch_hazard_ctl.sv
`timescale 1ns/1ps
module test_branch_hazard_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_branch;
  logic [4:0]  id_rs, id_rt, ex_dst, mem_dst, wb_dst;
  logic [31:0] id_rs_val, id_rt_val, id_pc_plus4, mem_alu_val, wb_val;
  logic [15:0] id_offset;
  logic        ex_wen, mem_wen, mem_load, wb_wen;
  logic [1:0]  fwd_a, fwd_b;
  logic        stall, flush, pc_sel;
  logic [31:0] br_target;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  branch_hazard_ctl i_branch_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .id_branch(id_branch), .id_rs(id_rs), .id_rt(id_rt),
    .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_pc_plus4(id_pc_plus4),
    .id_offset(id_offset), .ex_dst(ex_dst), .ex_wen(ex_wen), .mem_dst(mem_dst),
    .mem_wen(mem_wen), .mem_load(mem_load), .mem_alu_val(mem_alu_val),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_val(wb_val), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall(stall), .flush(flush), .pc_sel(pc_sel), .br_target(br_target));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear();
    id_branch = 0; id_rs = 0; id_rt = 0; id_rs_val = 0; id_rt_val = 0;
    id_pc_plus4 = 32'h100; id_offset = 0;
    ex_dst = 0; ex_wen = 0; mem_dst = 0; mem_wen = 0; mem_load = 0; mem_alu_val = 0;
    wb_dst = 0; wb_wen = 0; wb_val = 0;
  endtask

  task automatic edge_drive();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset_idle();
    edge_drive(); clear(); ex_dst = 3; ex_wen = 1; id_rs = 3; settle();
    check("R9 stall idle", {31'd0, stall}, 0);
    check("R9 redirect idle", {30'd0, flush, pc_sel}, 0);
  endtask

  task automatic t_target();
    edge_drive(); clear(); id_pc_plus4 = 32'h100; id_offset = 16'hFFFF; settle();
    check("R1 negative offset", br_target, 32'hFC);
    id_offset = 16'h0010; settle();
    check("R1 positive offset", br_target, 32'h140);
  endtask

  task automatic t_compare();
    edge_drive(); clear(); id_branch = 1; id_rs = 4; id_rt = 5;
    id_rs_val = 32'hABCD; id_rt_val = 32'hABCD; settle();
    check("R2 equal taken", {30'd0, flush, pc_sel}, 2'b11);
    id_rt_val = 32'hABCE; settle();
    check("R2 unequal not taken", {30'd0, flush, pc_sel}, 2'b00);
  endtask

  task automatic t_adjacent_alu();
    int dec = 0;
    edge_drive(); clear(); id_branch = 1; id_rs = 7; id_rt = 8;
    id_rs_val = 1; id_rt_val = 9; ex_dst = 7; ex_wen = 1; settle();
    check("R3 adjacent alu stalls", {31'd0, stall}, 1);
    check("R2 no redirect while stalled", {31'd0, pc_sel}, 0);
    dec++;
    edge_drive(); ex_wen = 0; ex_dst = 0; mem_dst = 7; mem_wen = 1; mem_alu_val = 9; settle();
    dec++;
    check("R3 forwarded after one stall", {31'd0, stall}, 0);
    check("R5 fwd_a mem", {30'd0, fwd_a}, 1);
    check("R5 taken with forwarded value", {31'd0, pc_sel}, 1);
    check("R3 decode cycles", dec, 2);
  endtask

  task automatic t_adjacent_load();
    int dec = 0;
    edge_drive(); clear(); id_branch = 1; id_rs = 2; id_rt = 6;
    id_rs_val = 0; id_rt_val = 32'h55; ex_dst = 6; ex_wen = 1; settle();
    check("R6 cycle1 stall", {31'd0, stall}, 1);
    dec++;
    edge_drive(); ex_wen = 0; ex_dst = 0; mem_dst = 6; mem_wen = 1; mem_load = 1; settle();
    check("R6 cycle2 stall", {31'd0, stall}, 1);
    check("R4 load in mem stalls", {31'd0, stall}, 1);
    dec++;
    edge_drive(); mem_wen = 0; mem_dst = 0; mem_load = 0; wb_dst = 6; wb_wen = 1; wb_val = 0; settle();
    dec++;
    check("R6 cycle3 resolves", {31'd0, stall}, 0);
    check("R5 fwd_b wb", {30'd0, fwd_b}, 2);
    check("R6 taken on wb value", {31'd0, pc_sel}, 1);
    check("R6 decode cycles", dec, 3);
  endtask

  task automatic t_load_two_back();
    edge_drive(); clear(); id_branch = 1; id_rs = 9; id_rt = 10;
    mem_dst = 9; mem_wen = 1; mem_load = 1; settle();
    check("R4 load two back stalls", {31'd0, stall}, 1);
    edge_drive(); mem_wen = 0; mem_load = 0; mem_dst = 0; wb_dst = 9; wb_wen = 1; settle();
    check("R4 one stall then free", {31'd0, stall}, 0);
    check("R5 fwd_a wb", {30'd0, fwd_a}, 2);
  endtask

  task automatic t_older_alu();
    edge_drive(); clear(); id_branch = 1; id_rs = 11; id_rt = 12;
    mem_dst = 12; mem_wen = 1; wb_dst = 11; wb_wen = 1; settle();
    check("R5 no stall older alu", {31'd0, stall}, 0);
    check("R5 fwd_b mem", {30'd0, fwd_b}, 1);
    check("R5 fwd_a wb", {30'd0, fwd_a}, 2);
  endtask

  task automatic t_ignored();
    edge_drive(); clear(); id_branch = 1; id_rs = 0; id_rt = 0;
    ex_dst = 0; ex_wen = 1; mem_dst = 0; mem_wen = 1; mem_load = 1; settle();
    check("R7 reg0 no stall", {31'd0, stall}, 0);
    check("R7 reg0 no forward", {28'd0, fwd_a, fwd_b}, 0);
    edge_drive(); clear(); id_branch = 1; id_rs = 13; id_rt = 14;
    ex_dst = 13; ex_wen = 0; mem_dst = 14; mem_wen = 0; mem_load = 1; settle();
    check("R7 wen low no stall", {31'd0, stall}, 0);
    check("R7 wen low no forward", {28'd0, fwd_a, fwd_b}, 0);
  endtask

  task automatic t_priority();
    edge_drive(); clear(); id_branch = 1; id_rs = 15; id_rt = 16;
    id_rt_val = 32'h77; mem_dst = 15; mem_wen = 1; mem_alu_val = 32'h77;
    wb_dst = 15; wb_wen = 1; wb_val = 32'h99; settle();
    check("R8 youngest select", {30'd0, fwd_a}, 1);
    check("R8 youngest value used", {31'd0, pc_sel}, 1);
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R9 reset outputs", {27'd0, stall, flush, pc_sel, fwd_a == 0, fwd_b == 0}, 32'b11);
    t_reset_idle();
    t_target();
    t_compare();
    t_adjacent_alu();
    t_adjacent_load();
    t_load_two_back();
    t_older_alu();
    t_ignored();
    t_priority();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule